// File: doc/BRIEF.md
# Windowed Level Event Detector

This block watches one stream of signed samples, one sample per valid strobe, and decides whether a level condition has persisted. Each accepted sample is turned into a magnitude and compared with a programmable threshold. Over a window of a programmable number of accepted samples, the block counts how many magnitudes lie above the threshold and how many do not. When the window closes, a majority vote between the two counts decides the verdict.

A mode input selects the sense of the vote. In low mode the block flags a dip, such as a supply voltage falling away. In high mode it flags an excess, such as a voltage rise or too much current. A positive verdict sets a sticky status flag and raises a one-cycle event pulse. The flag stays set until a clear strobe arrives. A window length of zero switches detection off. Windows follow one another with no gap and no overlap.

Top module: `window_level_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it, `flag` and `event_pulse` are both 0.
- R2: When `duration` is 0, no window closes, `event_pulse` stays 0 and `flag` is never set, whatever samples arrive.
- R3: The magnitude of each accepted sample is its absolute value. A magnitude strictly greater than `level` counts as above. A magnitude equal to or less than `level` counts as below.
- R4: The most negative sample value (0x8000 at 16 bits) rectifies to the largest positive magnitude (0x7FFF).
- R5: With `mode_high` = 0, a window verdict is positive when the below count exceeds the above count.
- R6: With `mode_high` = 1, a window verdict is positive when the above count exceeds the below count.
- R7: When the two counts of a window are equal, the verdict is negative in either mode.
- R8: `flag` holds its value until `clr` is 1. When `clr` is 1 at the same clock edge as a positive verdict, `flag` ends up 0.
- R9: A positive verdict raises `event_pulse` for exactly the cycle after the clock edge that accepts the window's last sample. `flag` reads 1 in that same cycle unless `clr` was applied. The pulse also fires when `clr` is applied at that edge.
- R10: A window closes after `duration` accepted samples. The next accepted sample opens a new window, so a positive verdict is possible every `duration` samples.
- R11: A change of `duration` discards the current partial window and any sample offered in that cycle. Counting restarts with the next accepted sample.
- R12: Samples offered while `smp_valid` is 0 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| level | input | SAMPLE_W | Unsigned threshold for the magnitude |
| duration | input | DUR_W | Window length in samples; 0 disables |
| mode_high | input | 1 | 1 selects the high-condition vote, 0 the low-condition vote |
| clr | input | 1 | Clears the sticky flag |
| flag | output | 1 | Sticky detection status |
| event_pulse | output | 1 | One-cycle pulse on a positive window verdict |

## Verification
A window can close with a positive verdict at the same clock edge where software strobes the clear. The bench drives `clr` together with the final sample of a window whose vote is positive. The result is judged correct when the flag reads 0 in the next cycle while the event pulse still reads 1. A second collision is a change of `duration` in the same cycle as a sample that would otherwise decide the vote. The check there is that no event appears from the abandoned window.

// File: rtl/wlm_pkg.sv
package wlm_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_LOW  = 2'd1,
    VERD_HIGH = 2'd2
  } verdict_e;
endpackage

// File: rtl/wlm_rectify.sv
module wlm_rectify #(
  parameter int W = 16
) (
  input  logic [W-1:0] data,
  output logic [W-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (data == MOST_NEG)    mag = MOST_POS;
    else if (data[W-1])      mag = -data;
    else                     mag = data;
  end
endmodule

// File: rtl/wlm_window.sv
module wlm_window #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  input  logic          above,
  input  logic [DW-1:0] dur,
  output logic          last,
  output logic [DW-1:0] tot_above,
  output logic [DW-1:0] tot_below
);
  logic [DW-1:0] cnt_a, cnt_b, idx;

  assign last      = step && (idx == dur - 1'b1);
  assign tot_above = cnt_a + {{(DW-1){1'b0}}, above};
  assign tot_below = cnt_b + {{(DW-1){1'b0}}, ~above};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_a <= '0;
      cnt_b <= '0;
      idx   <= '0;
    end else if (step) begin
      if (last) begin
        cnt_a <= '0;
        cnt_b <= '0;
        idx   <= '0;
      end else begin
        cnt_a <= tot_above;
        cnt_b <= tot_below;
        idx   <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wlm_status.sv
module wlm_status #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_end,
  input  logic          mode_high,
  input  logic [DW-1:0] tot_above,
  input  logic [DW-1:0] tot_below,
  input  logic          clr,
  output logic          flag,
  output logic          evt
);
  import wlm_pkg::*;
  verdict_e verdict;
  logic     hit;

  always_comb begin
    if (tot_above > tot_below)      verdict = VERD_HIGH;
    else if (tot_below > tot_above) verdict = VERD_LOW;
    else                            verdict = VERD_NONE;
    hit = win_end && (mode_high ? (verdict == VERD_HIGH) : (verdict == VERD_LOW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      evt  <= 1'b0;
    end else begin
      evt <= hit;
      if (clr)      flag <= 1'b0;
      else if (hit) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/window_level_monitor.sv
module window_level_monitor #(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [DUR_W-1:0]    duration,
  input  logic                mode_high,
  input  logic                clr,
  output logic                flag,
  output logic                event_pulse
);
  logic [SAMPLE_W-1:0] mag;
  logic [DUR_W-1:0]    dur_q;
  logic                enabled, restart, step, above, last;
  logic [DUR_W-1:0]    tot_a, tot_b;

  always_ff @(posedge clk) begin
    if (rst) dur_q <= '0;
    else     dur_q <= duration;
  end

  assign enabled = (duration != '0);
  assign restart = (duration != dur_q) || !enabled;
  assign step    = smp_valid && enabled && !restart;
  assign above   = (mag > level);

  wlm_rectify #(.W(SAMPLE_W)) u_rect (
    .data (smp_data),
    .mag  (mag)
  );

  wlm_window #(.DW(DUR_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .step      (step),
    .above     (above),
    .dur       (duration),
    .last      (last),
    .tot_above (tot_a),
    .tot_below (tot_b)
  );

  wlm_status #(.DW(DUR_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .win_end   (last),
    .mode_high (mode_high),
    .tot_above (tot_a),
    .tot_below (tot_b),
    .clr       (clr),
    .flag      (flag),
    .evt       (event_pulse)
  );
endmodule

// File: rtl/wlm_checker.sv
module wlm_checker #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [DUR_W-1:0] duration,
  input logic             clr,
  input logic             flag,
  input logic             event_pulse
);
  // R2: a disabled window never produces an event
  a_r2_zero_dur_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(duration) == '0)) |-> !event_pulse);

  // R8: clear wins over a set in the same cycle
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr)) |-> !flag);

  // R8: flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R9: an event without a clear leaves the flag set
  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (event_pulse && !$past(rst) && !$past(clr)) |-> flag);

  // R9: the flag only rises together with an event
  a_r9_rise_with_event: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> event_pulse);
endmodule

bind window_level_monitor wlm_checker #(.DUR_W(DUR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .duration    (duration),
  .clr         (clr),
  .flag        (flag),
  .event_pulse (event_pulse)
);

// File: tb/window_level_monitor_test.sv
module window_level_monitor_test;
  localparam int SW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [SW-1:0] level = '0;
  logic [DW-1:0] duration = '0;
  logic          mode_high = 1'b0;
  logic          clr = 1'b0;
  logic          flag, event_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  window_level_monitor #(.SAMPLE_W(SW), .DUR_W(DW)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .level(level), .duration(duration), .mode_high(mode_high), .clr(clr),
    .flag(flag), .event_pulse(event_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
    clr = 1'b0;
    tick();
  endtask

  task automatic send(input logic [SW-1:0] v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = v;
    clr = 1'b0;
    tick();
  endtask

  task automatic cfg(input logic mh, input int lvl, input int dur);
    @(negedge clk);
    smp_valid = 1'b0;
    duration = '0;
    tick();
    @(negedge clk);
    mode_high = mh;
    level = SW'(lvl);
    duration = DW'(dur);
    tick();
  endtask

  task automatic do_clear();
    @(negedge clk);
    smp_valid = 1'b0;
    clr = 1'b1;
    tick();
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag in reset", flag, 0);
    chk("R1 event in reset", event_pulse, 0);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 flag after reset", flag, 0);
    chk("R1 event after reset", event_pulse, 0);
  endtask

  task automatic t_zero_dur();
    int ev = 0;
    cfg(1'b1, 100, 0);
    for (int i = 0; i < 8; i++) begin
      send(16'd500);
      ev += event_pulse;
    end
    idle();
    chk("R2 no event with zero duration", ev, 0);
    chk("R2 no flag with zero duration", flag, 0);
  endtask

  task automatic t_sag();
    cfg(1'b0, 100, 4);
    send(16'd10);
    send(-16'sd20);
    send(16'd200);
    chk("R10 no event mid window", event_pulse, 0);
    send(16'd100);
    chk("R5 sag event", event_pulse, 1);
    chk("R5 sag flag", flag, 1);
    idle();
    chk("R9 event lasts one cycle", event_pulse, 0);
    for (int i = 0; i < 5; i++) idle();
    chk("R8 flag sticky", flag, 1);
    do_clear();
    chk("R8 clear drops flag", flag, 0);
  endtask

  task automatic t_swell();
    cfg(1'b1, 100, 3);
    send(-16'sd150);
    send(16'd150);
    send(16'd50);
    chk("R6 swell event (R3 negative rectified)", event_pulse, 1);
    chk("R6 swell flag", flag, 1);
    idle();
    do_clear();
  endtask

  task automatic t_tie();
    int ev = 0;
    cfg(1'b1, 100, 4);
    send(16'd200); send(16'd200); send(16'd10); send(16'd10);
    ev += event_pulse;
    cfg(1'b0, 100, 4);
    send(16'd200); send(16'd200); send(16'd10); send(16'd10);
    ev += event_pulse;
    idle();
    chk("R7 tie gives no event", ev, 0);
    chk("R7 tie gives no flag", flag, 0);
  endtask

  task automatic t_equal();
    cfg(1'b1, 100, 2);
    send(16'd100); send(-16'sd100);
    chk("R3 equal is not above (high mode)", event_pulse, 0);
    cfg(1'b0, 100, 2);
    send(16'd100); send(-16'sd100);
    chk("R3 equal counts below (low mode)", event_pulse, 1);
    idle();
    do_clear();
  endtask

  task automatic t_sat();
    cfg(1'b1, 32766, 1);
    send(16'h8000);
    chk("R4 most negative saturates above level", event_pulse, 1);
    idle();
    do_clear();
    cfg(1'b0, 32767, 1);
    send(16'h8000);
    chk("R4 saturated magnitude equals max, counts below", event_pulse, 1);
    idle();
    do_clear();
  endtask

  task automatic t_b2b();
    int e1, e2, e3;
    cfg(1'b1, 100, 2);
    send(16'd200); send(16'd200); e1 = event_pulse;
    send(16'd10);  send(16'd10);  e2 = event_pulse;
    send(16'd200); send(16'd200); e3 = event_pulse;
    chk("R10 first window event", e1, 1);
    chk("R10 second window quiet", e2, 0);
    chk("R10 third window event", e3, 1);
    idle();
    do_clear();
  endtask

  task automatic t_dur_change();
    int ev = 0;
    cfg(1'b1, 100, 4);
    send(16'd200); send(16'd200); send(16'd200);
    @(negedge clk);
    duration = 16'd2;
    smp_valid = 1'b1;
    smp_data = 16'd200;
    tick();
    ev += event_pulse;
    send(16'd10); ev += event_pulse;
    send(16'd10); ev += event_pulse;
    chk("R11 restart drops old window", ev, 0);
    send(16'd200); send(16'd200);
    chk("R11 new length applies", event_pulse, 1);
    idle();
    do_clear();
  endtask

  task automatic t_invalid();
    cfg(1'b1, 100, 2);
    send(16'd200);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data = 16'd300;
    tick(); tick(); tick();
    chk("R12 invalid sample ignored", event_pulse, 0);
    send(16'd10);
    chk("R12 window of valid samples ties", event_pulse, 0);
    chk("R12 flag unchanged", flag, 0);
    idle();
  endtask

  task automatic t_clr_collide();
    cfg(1'b1, 100, 2);
    send(16'd200);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = 16'd200;
    clr = 1'b1;
    tick();
    chk("R9 event fires with clear", event_pulse, 1);
    chk("R8 clear wins over set", flag, 0);
    idle();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_zero_dur();
    t_sag();
    t_swell();
    t_tie();
    t_equal();
    t_sat();
    t_b2b();
    t_dur_change();
    t_invalid();
    t_clr_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule